// File: doc/BRIEF.md
# Periodic Countdown Interrupt Timer

This block is a reloading down-counter that produces a periodic interrupt. It counts pulses from one of four tick sources. Two of the sources are fast ticks that an internal prescaler divides from the reference clock. The other two are second-boundary and minute-boundary strobes that come from a calendar elsewhere on the chip. Software sets a 12-bit period value and picks a source, then sets the run bit. Each time the period runs out, the block sets a sticky status flag. If the interrupt is enabled, it also drives an active-low request for a fixed number of reference-clock cycles. The counter then reloads and keeps running without help.

The block runs entirely in the reference clock domain. A countdown state machine has three states. `CD_IDLE` is the state after reset. `CD_RUN` is the counting state. `CD_HALT` means stopped by software. These transitions exist: IDLE→RUN and HALT→RUN on the run bit going high, both of which load the period value, and RUN→HALT on the run bit going low, which freezes the count. A second state machine shapes the request. It has two states, `IRQ_REL` (released) and `IRQ_DRIVE` (driving low). REL→DRIVE happens on an enabled expiry. DRIVE→DRIVE restarts the width when another enabled expiry arrives. DRIVE→REL happens when the width counter is used up.

Top module: `cycle_timer_top`

## Requirements
- R1: After reset `tmr_flag` is 0 and `irq_n` is 1.
- R2: With `src_sel` = 2'b10 (second strobe) or 2'b11 (minute strobe), the period expires on the Nth selected strobe after the run bit is set, where N is `period`. The count then reloads and the next expiry comes N strobes later. The flag and the request change on the clock edge that samples the expiring strobe.
- R3: With `src_sel` = 2'b00 the tick is the clock divided by `FAST_DIV`. With 2'b01 it is the clock divided by `SLOW_DIV`. Successive expiries are `period` × divider clock cycles apart.
- R4: `tmr_flag` goes to 1 on every expiry and holds until a cycle with `flag_clr` = 1 and no expiry. An expiry in the same cycle as `flag_clr` leaves the flag at 1.
- R5: On an expiry with `irq_en` = 1, `irq_n` is low for exactly `PULSE_W` clock cycles and then releases, while `tmr_flag` stays 1.
- R6: On an expiry with `irq_en` = 0, `irq_n` stays 1 and `tmr_flag` still becomes 1.
- R7: While `tmr_en` is 0 no strobe causes an expiry. Setting `tmr_en` to 1 again restarts the count from the full `period`.
- R8: Strobes on a tick source that is not selected have no effect on the count.
- R9: A `period` of 000h never produces an expiry.
- R10: An enabled expiry that arrives while `irq_n` is already low restarts the width, so `irq_n` releases `PULSE_W` cycles after the last expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe at each second boundary |
| min_tick | input | 1 | One-cycle strobe at each minute boundary |
| tmr_en | input | 1 | Run bit; a rising level loads `period` |
| src_sel | input | 2 | Tick source: 00 fast, 01 slow, 10 second, 11 minute |
| period | input | CNT_W | Countdown start value, 1 to 2^CNT_W-1 |
| irq_en | input | 1 | Allows the request pulse on expiry |
| flag_clr | input | 1 | One-cycle write that clears the flag |
| tmr_flag | output | 1 | Sticky expiry flag |
| irq_n | output | 1 | Active-low self-releasing interrupt request |

## Verification
The bench builds the block with `FAST_DIV` = 4, `SLOW_DIV` = 16 and `PULSE_W` = 6, keeping `CNT_W` at 12. With these values the prescaled periods are 12 and 32 cycles, so the fast and slow sources can be measured edge to edge in a few hundred cycles. With the short width, strobes three cycles apart land inside a running pulse, which exercises the retrigger path. The second and minute strobes are driven directly by the bench, so the expected expiry cycles are exact and are queued for comparison.

// File: rtl/cycle_timer_pkg.sv
package cycle_timer_pkg;

    typedef enum logic [1:0] {
        SRC_FAST = 2'b00,
        SRC_SLOW = 2'b01,
        SRC_SEC  = 2'b10,
        SRC_MIN  = 2'b11
    } tick_src_e;

    typedef enum logic [1:0] {
        CD_IDLE = 2'b00,
        CD_RUN  = 2'b01,
        CD_HALT = 2'b10
    } cd_state_e;

    typedef enum logic {
        IRQ_REL   = 1'b0,
        IRQ_DRIVE = 1'b1
    } irq_state_e;

endpackage

// File: rtl/ct_divider.sv
module ct_divider #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/ct_tick_select.sv
module ct_tick_select
    import cycle_timer_pkg::*;
(
    input  logic       fast_tick,
    input  logic       slow_tick,
    input  logic       sec_tick,
    input  logic       min_tick,
    input  logic [1:0] sel,
    output logic       tick
);
    tick_src_e src;

    always_comb begin
        src = tick_src_e'(sel);
        unique case (src)
            SRC_FAST: tick = fast_tick;
            SRC_SLOW: tick = slow_tick;
            SRC_SEC:  tick = sec_tick;
            SRC_MIN:  tick = min_tick;
            default:  tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/ct_countdown.sv
module ct_countdown
    import cycle_timer_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cd_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             step;
    logic             load;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CD_IDLE: if (en)  state_d = CD_RUN;
            CD_RUN:  if (!en) state_d = CD_HALT;
            CD_HALT: if (en)  state_d = CD_RUN;
            default:          state_d = CD_IDLE;
        endcase
    end

    // outputs of the machine
    always_comb begin
        load   = (state_q != CD_RUN) && en;
        step   = (state_q == CD_RUN) && en && tick;
        expire = step && (cnt_q == ONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= period;
        end else if (step) begin
            if (cnt_q == ONE || cnt_q == '0) begin
                cnt_q <= period;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/ct_irq_gen.sv
module ct_irq_gen
    import cycle_timer_pkg::*;
#(
    parameter int PULSE_W = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic irq_en,
    input  logic flag_clr,
    output logic flag,
    output logic irq_n
);
    localparam int PW = $clog2(PULSE_W + 1);
    localparam logic [PW-1:0] PW_LOAD = PW'(PULSE_W - 1);

    irq_state_e    state_q, state_d;
    logic [PW-1:0] pw_q;
    logic          fire;

    assign fire = expire && irq_en;

    // sticky flag: set beats clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (expire) begin
            flag <= 1'b1;
        end else if (flag_clr) begin
            flag <= 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_REL;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_REL:   if (fire) state_d = IRQ_DRIVE;
            IRQ_DRIVE: if (!fire && pw_q == '0) state_d = IRQ_REL;
            default:   state_d = IRQ_REL;
        endcase
    end

    // width counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pw_q <= '0;
        end else if (fire) begin
            pw_q <= PW_LOAD;
        end else if (state_q == IRQ_DRIVE && pw_q != '0) begin
            pw_q <= pw_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        irq_n = (state_q != IRQ_DRIVE);
    end
endmodule

// File: rtl/cycle_timer_top.sv
module cycle_timer_top #(
    parameter int CNT_W    = 12,
    parameter int FAST_DIV = 8,
    parameter int SLOW_DIV = 512,
    parameter int PULSE_W  = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_tick,
    input  logic             min_tick,
    input  logic             tmr_en,
    input  logic [1:0]       src_sel,
    input  logic [CNT_W-1:0] period,
    input  logic             irq_en,
    input  logic             flag_clr,
    output logic             tmr_flag,
    output logic             irq_n
);
    localparam int N_DIV = 2;

    logic [N_DIV-1:0] div_tick;
    logic             sel_tick;
    logic             expire_w;

    for (genvar i = 0; i < N_DIV; i++) begin : g_div
        ct_divider #(
            .DIV((i == 0) ? FAST_DIV : SLOW_DIV)
        ) u_div (
            .clk  (clk),
            .rst_n(rst_n),
            .tick (div_tick[i])
        );
    end

    ct_tick_select u_sel (
        .fast_tick(div_tick[0]),
        .slow_tick(div_tick[1]),
        .sec_tick (sec_tick),
        .min_tick (min_tick),
        .sel      (src_sel),
        .tick     (sel_tick)
    );

    ct_countdown #(
        .CNT_W(CNT_W)
    ) u_cd (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (tmr_en),
        .tick  (sel_tick),
        .period(period),
        .expire(expire_w)
    );

    ct_irq_gen #(
        .PULSE_W(PULSE_W)
    ) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .expire  (expire_w),
        .irq_en  (irq_en),
        .flag_clr(flag_clr),
        .flag    (tmr_flag),
        .irq_n   (irq_n)
    );
endmodule

// File: rtl/cycle_timer_chk.sv
module cycle_timer_chk #(
    parameter int PULSE_W = 256
) (
    input logic clk,
    input logic rst_n,
    input logic tmr_en,
    input logic irq_en,
    input logic flag_clr,
    input logic tmr_flag,
    input logic irq_n,
    input logic expire
);
    int since_exp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_exp <= PULSE_W;
        end else if (expire) begin
            since_exp <= 0;
        end else if (since_exp < PULSE_W) begin
            since_exp <= since_exp + 1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (irq_n && !tmr_flag)) else $error("reset"); // R1
    AST_SET_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n) $rose(tmr_flag) |-> $past(expire)) else $error("set"); // R2
    AST_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n) $fell(tmr_flag) |-> $past(flag_clr)) else $error("clear"); // R4
    AST_FLAG_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n) $fell(irq_n) |-> tmr_flag) else $error("flag"); // R5
    AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n) !irq_n |-> (since_exp < PULSE_W)) else $error("width"); // R10
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) $fell(irq_n) |-> ($past(irq_en) && $past(expire))) else $error("gate"); // R6
    AST_NO_RUN_OFF: assert property (@(posedge clk) disable iff (!rst_n) expire |-> tmr_en) else $error("run"); // R7
endmodule

bind cycle_timer_top cycle_timer_chk #(.PULSE_W(PULSE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tmr_en  (tmr_en),
    .irq_en  (irq_en),
    .flag_clr(flag_clr),
    .tmr_flag(tmr_flag),
    .irq_n   (irq_n),
    .expire  (expire_w)
);

// File: tb/cycle_timer_top_tb.sv
`timescale 1ns/1ps
module cycle_timer_top_tb;
    localparam int CNT_W = 12;
    localparam int FD    = 4;
    localparam int SD    = 16;
    localparam int PW    = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sec_tick = 1'b0;
    logic             min_tick = 1'b0;
    logic             tmr_en = 1'b0;
    logic [1:0]       src_sel = 2'b10;
    logic [CNT_W-1:0] period = '0;
    logic             irq_en = 1'b0;
    logic             flag_clr = 1'b0;
    logic             tmr_flag;
    logic             irq_n;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int exp_q[$];
    bit sb_on = 1'b0;
    bit prev_irq = 1'b1;
    int low_run = 0;
    int last_width = 0;
    int last_fall = 0;
    bit have_last = 1'b0;
    int last_gap = 0;
    int n_gaps = 0;
    bit done = 1'b0;

    cycle_timer_top #(
        .CNT_W(CNT_W), .FAST_DIV(FD), .SLOW_DIV(SD), .PULSE_W(PW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .min_tick(min_tick),
        .tmr_en(tmr_en), .src_sel(src_sel), .period(period), .irq_en(irq_en),
        .flag_clr(flag_clr), .tmr_flag(tmr_flag), .irq_n(irq_n)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    // monitor: scoreboard on request falls, width and gap log
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_irq && !irq_n) begin
                if (sb_on) begin
                    if (exp_q.size() == 0) begin
                        check("R6 R7 R8 R9 unexpected request", cyc, -1);
                    end else begin
                        check("R2 expiry cycle", cyc, exp_q.pop_front());
                    end
                end else begin
                    if (have_last) begin
                        last_gap = cyc - last_fall;
                        n_gaps++;
                    end
                    last_fall = cyc;
                    have_last = 1'b1;
                end
            end
            if (!irq_n) low_run++;
            else if (!prev_irq) begin
                last_width = low_run;
                low_run = 0;
            end
            prev_irq = irq_n;
        end
    end

    // driver: one strobe, optionally queueing the expected expiry
    task automatic strobe(input bit use_min, input bit expect_exp);
        @(negedge clk);
        if (use_min) min_tick = 1'b1; else sec_tick = 1'b1;
        if (expect_exp) exp_q.push_back(cyc + 1);
        @(negedge clk);
        min_tick = 1'b0;
        sec_tick = 1'b0;
        repeat (PW + 2) @(negedge clk);
    endtask

    task automatic restart(input logic [1:0] s, input int p);
        @(negedge clk);
        tmr_en = 1'b0;
        @(negedge clk);
        src_sel = s;
        period = CNT_W'(p);
        tmr_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic clear_flag();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check("watchdog", 1, 0);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 flag after reset", tmr_flag, 0);
        check("R1 irq_n after reset", irq_n, 1);

        // R2: second strobe source, reload after expiry
        irq_en = 1'b1;
        sb_on = 1'b1;
        restart(2'b10, 3);
        strobe(0, 0); strobe(0, 0); strobe(0, 1);
        check("R5 width", last_width, PW);
        check("R5 irq released", irq_n, 1);
        check("R4 flag sticky", tmr_flag, 1);
        strobe(0, 0); strobe(0, 0); strobe(0, 1);
        clear_flag();
        check("R4 flag cleared", tmr_flag, 0);

        // R2 minute source, R8 second strobes ignored
        restart(2'b11, 2);
        strobe(0, 0); strobe(0, 0);
        check("R8 unselected strobes", tmr_flag, 0);
        strobe(1, 0); strobe(1, 1); strobe(1, 0); strobe(1, 1);
        clear_flag();

        // R4 set beats clear in the same cycle
        restart(2'b10, 1);
        @(negedge clk);
        sec_tick = 1'b1;
        flag_clr = 1'b1;
        exp_q.push_back(cyc + 1);
        @(negedge clk);
        sec_tick = 1'b0;
        flag_clr = 1'b0;
        check("R4 set wins over clear", tmr_flag, 1);
        repeat (PW + 2) @(negedge clk);
        clear_flag();

        // R6 interrupt disabled
        irq_en = 1'b0;
        strobe(0, 0);
        check("R6 flag without irq", tmr_flag, 1);
        check("R6 irq_n stays high", irq_n, 1);
        irq_en = 1'b1;
        clear_flag();

        // R7 stop holds, re-enable reloads full period
        restart(2'b10, 3);
        strobe(0, 0); strobe(0, 0);
        @(negedge clk);
        tmr_en = 1'b0;
        for (int i = 0; i < 5; i++) strobe(0, 0);
        check("R7 no expiry while stopped", tmr_flag, 0);
        @(negedge clk);
        tmr_en = 1'b1;
        @(negedge clk);
        strobe(0, 0); strobe(0, 0);
        check("R7 reload from full period", tmr_flag, 0);
        strobe(0, 1);
        check("R7 expiry after reload", tmr_flag, 1);
        clear_flag();

        // R9 zero period
        restart(2'b10, 0);
        for (int i = 0; i < 6; i++) strobe(0, 0);
        check("R9 zero period", tmr_flag, 0);

        // R10 retrigger within a running pulse
        restart(2'b10, 1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            sec_tick = 1'b1;
            if (i == 0) exp_q.push_back(cyc + 1);
            @(negedge clk);
            sec_tick = 1'b0;
            @(negedge clk);
        end
        repeat (PW + 6) @(negedge clk);
        check("R10 stretched width", last_width, 3 * 3 + PW);
        check("R2 queue drained", exp_q.size(), 0);
        clear_flag();

        // R3 prescaled sources, measured edge to edge
        sb_on = 1'b0;
        restart(2'b00, 3);
        have_last = 1'b0;
        n_gaps = 0;
        for (int i = 0; i < 200 && n_gaps < 2; i++) @(negedge clk);
        check("R3 fast period", last_gap, 3 * FD);
        restart(2'b01, 2);
        have_last = 1'b0;
        n_gaps = 0;
        for (int i = 0; i < 400 && n_gaps < 2; i++) @(negedge clk);
        check("R3 slow period", last_gap, 2 * SD);

        finish_run();
    end
endmodule